// File: doc/BRIEF.md
# CAN Error Flag and Code Capture

This block holds the error-reporting registers of a CAN controller. Error detection happens elsewhere. Each bus-level event and each protocol error kind arrives here as a one-cycle pulse. The block latches these pulses into sticky flags and keeps a separate record of which protocol error kinds occurred. It also combines the enabled flags into one error interrupt.

Software clears flags by writing a zero to each flag it has handled. Bits written as one keep their value, so a handler can clear exactly the bits it read without losing events that arrived in the meantime. The error code record has two modes. In one mode it shows only the most recent error. In the other it gathers error kinds until software clears them. The transmit and receive error counter values come in from the protocol engine and are read through the same register port.

The write port and the read port are separate. Reads are combinational from the registered state. A write or an event takes effect at the clock edge and is visible on the read port after that edge.

Top module: `can_err_capture`

## Requirements
- R1: After reset, the factor, enable, code, interrupt-status and interrupt-enable registers all read 0, and `err_irq_o` is 0.
- R2: A pulse on `fevt_i[k]` sets factor bit k+1 at the next edge, and the bit stays set until it is cleared. Factor bit layout: 7 bus lock, 6 overload frame sent, 5 receive overrun, 4 bus-off recovery, 3 bus-off entry, 2 error passive, 1 error warning.
- R3: A cycle with any bit of `perr_i` high sets factor bit 0 (bus error).
- R4: A write to the factor register (address 0) clears each flag whose data bit is 0 and leaves each flag whose data bit is 1 unchanged.
- R5: When a set event and a clearing write hit the same flag in the same cycle, the flag ends up set. This applies to both the factor register and the code register.
- R6: With code register bit 7 at 0 (last-error mode), a cycle with any `perr_i` bit high replaces code bits 6:0 with exactly the `perr_i` bits of that cycle. Code bit layout: 6 ACK delimiter, 5 dominant bit error, 4 recessive bit error, 3 CRC, 2 ACK, 1 form, 0 stuff.
- R7: With code register bit 7 at 1 (accumulate mode), `perr_i` bits are ORed into code bits 6:0, and earlier bits are kept.
- R8: A write to the code register (address 2) clears bits 6:0 where the data is 0 and keeps them where it is 1. Bit 7 takes the written value directly.
- R9: The enable register (address 1) is read/write. Interrupt-status bit 5 (address 5) reads 1 exactly when some factor bit and its enable bit are both 1. All other interrupt-status bits read 0.
- R10: Interrupt-enable bit 5 (address 6) is read/write, and the other bits of that register read 0. `err_irq_o` equals interrupt-status bit 5 ANDed with this enable bit.
- R11: Address 3 returns `tx_cnt_i` and address 4 returns `rx_cnt_i`, following the inputs as they change.
- R12: Writes to addresses 3, 4, 5 and 7 change nothing. Address 7 reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 3 | Write address |
| wr_data_i | input | 8 | Write data |
| rd_addr_i | input | 3 | Read address |
| rd_data_o | output | 8 | Combinational read data |
| fevt_i | input | 7 | Bus-level event pulses, bit k drives factor bit k+1 |
| perr_i | input | 7 | Protocol error pulses, in code bit order |
| tx_cnt_i | input | 8 | Transmit error counter value |
| rx_cnt_i | input | 8 | Receive error counter value |
| err_irq_o | output | 1 | Combined error interrupt |

## Verification
The assertions check the per-bit flag rules on every cycle:
- a pulse sets its flag on the next edge;
- a zero written without a competing event clears the flag;
- a one written without a competing event keeps the flag;
- any protocol error raises the bus-error factor;
- the code record is replaced in last-error mode and only grows in accumulate mode.

The bench scenarios cover the rest. These are the address decode and the read-back of each register, the combined status and interrupt gating through the enable registers, writes to read-only addresses, and the counters passing through. The scenarios also cover mode switching, where a single write both changes the mode and clears code bits.

// File: rtl/can_err_pkg.sv
package can_err_pkg;
   localparam int ADDR_W = 3;
   typedef logic [ADDR_W-1:0] addr_t;

   localparam addr_t ADR_FACTOR = 3'd0;
   localparam addr_t ADR_ENABLE = 3'd1;
   localparam addr_t ADR_CODE   = 3'd2;
   localparam addr_t ADR_TXCNT  = 3'd3;
   localparam addr_t ADR_RXCNT  = 3'd4;
   localparam addr_t ADR_ISTAT  = 3'd5;
   localparam addr_t ADR_IEN    = 3'd6;

   // bit position of the combined error status / enable
   localparam int ERR_SUM_BIT = 5;
endpackage

// File: rtl/can_err_flag_bank.sv
// Sticky flag bank: set events win over a write-zero clear; optional
// replace of the whole bank by the set vector.
module can_err_flag_bank #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] set_i,
   input  logic         wr_i,
   input  logic [W-1:0] wdata_i,
   input  logic         replace_i,
   output logic [W-1:0] q_o
);
   if (W < 1) begin : g_bad_w
      $error("flag bank width must be positive");
   end

   logic         any_set;
   logic         do_replace;
   logic [W-1:0] q;

   assign any_set    = |set_i;
   assign do_replace = replace_i & any_set;
   assign q_o        = q;

   for (genvar i = 0; i < W; i++) begin : g_bit
      logic keep;
      assign keep = q[i] & (~wr_i | wdata_i[i]);

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)          q[i] <= 1'b0;
         else if (do_replace) q[i] <= set_i[i];
         else                 q[i] <= set_i[i] | keep;
      end

      // R2 R5: an event always leaves its flag set
      a_r5_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
         set_i[i] |=> q_o[i]);
      // R4: a zero written with no competing event clears the flag
      a_r4_zero_clears: assert property (@(posedge clk) disable iff (!rst_n)
         (wr_i && !wdata_i[i] && !set_i[i]) |=> !q_o[i]);
      // R4: a one written with no event keeps the flag
      a_r4_one_keeps: assert property (@(posedge clk) disable iff (!rst_n)
         (wr_i && wdata_i[i] && !set_i[i] && !(replace_i && (|set_i)))
         |=> (q_o[i] == $past(q_o[i])));
   end
endmodule

// File: rtl/can_err_code_capture.sv
// Protocol error code record with last-error / accumulate mode bit.
module can_err_code_capture #(
   parameter int REG_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [REG_W-2:0] perr_i,
   input  logic             wr_i,
   input  logic [REG_W-1:0] wdata_i,
   output logic [REG_W-1:0] code_o,
   output logic             any_err_o
);
   localparam int CW = REG_W - 1;

   logic          acc_mode_q;
   logic [CW-1:0] bits;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    acc_mode_q <= 1'b0;
      else if (wr_i) acc_mode_q <= wdata_i[REG_W-1];
   end

   can_err_flag_bank #(.W(CW)) u_bits (
      .clk       (clk),
      .rst_n     (rst_n),
      .set_i     (perr_i),
      .wr_i      (wr_i),
      .wdata_i   (wdata_i[CW-1:0]),
      .replace_i (~acc_mode_q),
      .q_o       (bits)
   );

   assign code_o    = {acc_mode_q, bits};
   assign any_err_o = |perr_i;

   // R6: last-error mode replaces the record with the new error bits
   a_r6_last_replace: assert property (@(posedge clk) disable iff (!rst_n)
      (!acc_mode_q && (|perr_i)) |=> (bits == $past(perr_i)));
   // R7: accumulate mode never drops a bit unless written
   a_r7_accum_keeps: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_mode_q && !wr_i) |=> ((bits & $past(bits)) == $past(bits)));
endmodule

// File: rtl/can_err_readback.sv
// Read multiplexer over the register map.
module can_err_readback
   import can_err_pkg::*;
#(
   parameter int REG_W = 8,
   parameter int CNT_W = 8
) (
   input  addr_t            addr_i,
   input  logic [REG_W-1:0] factor_i,
   input  logic [REG_W-1:0] enable_i,
   input  logic [REG_W-1:0] code_i,
   input  logic [CNT_W-1:0] tx_cnt_i,
   input  logic [CNT_W-1:0] rx_cnt_i,
   input  logic [REG_W-1:0] istat_i,
   input  logic [REG_W-1:0] ien_i,
   output logic [REG_W-1:0] data_o
);
   if (CNT_W > REG_W) begin : g_bad_cnt
      $error("counter width exceeds register width");
   end

   logic [REG_W-1:0] tx_ext;
   logic [REG_W-1:0] rx_ext;

   if (CNT_W == REG_W) begin : g_cnt_full
      assign tx_ext = tx_cnt_i;
      assign rx_ext = rx_cnt_i;
   end else begin : g_cnt_pad
      assign tx_ext = {{(REG_W-CNT_W){1'b0}}, tx_cnt_i};
      assign rx_ext = {{(REG_W-CNT_W){1'b0}}, rx_cnt_i};
   end

   always_comb begin
      case (addr_i)
         ADR_FACTOR: data_o = factor_i;
         ADR_ENABLE: data_o = enable_i;
         ADR_CODE:   data_o = code_i;
         ADR_TXCNT:  data_o = tx_ext;
         ADR_RXCNT:  data_o = rx_ext;
         ADR_ISTAT:  data_o = istat_i;
         ADR_IEN:    data_o = ien_i;
         default:    data_o = '0;
      endcase
   end
endmodule

// File: rtl/can_err_capture.sv
// Top: error factor flags, enables, code record and combined interrupt.
module can_err_capture
   import can_err_pkg::*;
#(
   parameter int REG_W = 8,
   parameter int CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en_i,
   input  logic [2:0]       wr_addr_i,
   input  logic [REG_W-1:0] wr_data_i,
   input  logic [2:0]       rd_addr_i,
   output logic [REG_W-1:0] rd_data_o,
   input  logic [REG_W-2:0] fevt_i,
   input  logic [REG_W-2:0] perr_i,
   input  logic [CNT_W-1:0] tx_cnt_i,
   input  logic [CNT_W-1:0] rx_cnt_i,
   output logic             err_irq_o
);
   if (REG_W <= ERR_SUM_BIT) begin : g_bad_reg
      $error("register width too small for summary bit");
   end

   logic wr_factor, wr_enable, wr_code, wr_ien;
   assign wr_factor = wr_en_i && (wr_addr_i == ADR_FACTOR);
   assign wr_enable = wr_en_i && (wr_addr_i == ADR_ENABLE);
   assign wr_code   = wr_en_i && (wr_addr_i == ADR_CODE);
   assign wr_ien    = wr_en_i && (wr_addr_i == ADR_IEN);

   logic [REG_W-1:0] code;
   logic             any_perr;

   can_err_code_capture #(.REG_W(REG_W)) u_code (
      .clk       (clk),
      .rst_n     (rst_n),
      .perr_i    (perr_i),
      .wr_i      (wr_code),
      .wdata_i   (wr_data_i),
      .code_o    (code),
      .any_err_o (any_perr)
   );

   logic [REG_W-1:0] factor;
   logic [REG_W-1:0] factor_set;
   assign factor_set = {fevt_i, any_perr};

   can_err_flag_bank #(.W(REG_W)) u_factor (
      .clk       (clk),
      .rst_n     (rst_n),
      .set_i     (factor_set),
      .wr_i      (wr_factor),
      .wdata_i   (wr_data_i),
      .replace_i (1'b0),
      .q_o       (factor)
   );

   logic [REG_W-1:0] enable_q;
   logic             ien_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         enable_q <= '0;
         ien_q    <= 1'b0;
      end else begin
         if (wr_enable) enable_q <= wr_data_i;
         if (wr_ien)    ien_q    <= wr_data_i[ERR_SUM_BIT];
      end
   end

   logic             err_sum;
   logic [REG_W-1:0] istat;
   logic [REG_W-1:0] ien_view;

   assign err_sum = |(factor & enable_q);

   always_comb begin
      istat              = '0;
      istat[ERR_SUM_BIT] = err_sum;
      ien_view              = '0;
      ien_view[ERR_SUM_BIT] = ien_q;
   end

   assign err_irq_o = err_sum & ien_q;

   can_err_readback #(.REG_W(REG_W), .CNT_W(CNT_W)) u_rd (
      .addr_i   (rd_addr_i),
      .factor_i (factor),
      .enable_i (enable_q),
      .code_i   (code),
      .tx_cnt_i (tx_cnt_i),
      .rx_cnt_i (rx_cnt_i),
      .istat_i  (istat),
      .ien_i    (ien_view),
      .data_o   (rd_data_o)
   );

   // R3: any protocol error raises the bus error factor
   a_r3_bus_err: assert property (@(posedge clk) disable iff (!rst_n)
      (|perr_i) |=> factor[0]);
   // R10: the interrupt cannot rise without its enable having been written
   a_r10_irq_gate: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ien_q) |-> $past(wr_ien));
endmodule

// File: tb/can_err_capture_bench.sv
`timescale 1ns/1ps
module can_err_capture_bench;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       wr_en = 1'b0;
   logic [2:0] wr_addr = '0;
   logic [7:0] wr_data = '0;
   logic [2:0] rd_addr = '0;
   logic [7:0] rd_data;
   logic [6:0] fevt = '0;
   logic [6:0] perr = '0;
   logic [7:0] tx_cnt = 8'h11;
   logic [7:0] rx_cnt = 8'h22;
   logic       err_irq;

   always #2.5 clk = ~clk;

   can_err_capture u_can_err_capture (
      .clk(clk), .rst_n(rst_n), .wr_en_i(wr_en), .wr_addr_i(wr_addr),
      .wr_data_i(wr_data), .rd_addr_i(rd_addr), .rd_data_o(rd_data),
      .fevt_i(fevt), .perr_i(perr), .tx_cnt_i(tx_cnt), .rx_cnt_i(rx_cnt),
      .err_irq_o(err_irq)
   );

   typedef struct {
      bit         pin;
      logic [7:0] exp;
      string      req;
   } item_t;

   item_t sb[$];
   int    checks = 0;
   int    errors = 0;
   bit    done = 0;
   event  smp;

   // monitor: pops the expected item and compares against the outputs
   always @(smp) begin
      item_t it;
      logic [7:0] got;
      it  = sb.pop_front();
      got = it.pin ? {7'b0, err_irq} : rd_data;
      checks++;
      if (got !== it.exp) begin
         errors++;
         $display("FAIL %s: got %02h expected %02h", it.req, got, it.exp);
      end
   end

   task automatic chk(input logic [2:0] a, input logic [7:0] e, input string r);
      item_t it;
      @(negedge clk);
      rd_addr = a;
      it.pin = 0; it.exp = e; it.req = r;
      sb.push_back(it);
      #1 -> smp;
   endtask

   task automatic chk_irq(input logic e, input string r);
      item_t it;
      @(negedge clk);
      it.pin = 1; it.exp = {7'b0, e}; it.req = r;
      sb.push_back(it);
      #1 -> smp;
   endtask

   task automatic drive(input logic w, input logic [2:0] a, input logic [7:0] d,
                        input logic [6:0] f, input logic [6:0] p);
      @(negedge clk);
      wr_en = w; wr_addr = a; wr_data = d; fevt = f; perr = p;
      @(negedge clk);
      wr_en = 0; fevt = '0; perr = '0;
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R1 reset state
      chk(3'd0, 8'h00, "R1 factor");
      chk(3'd1, 8'h00, "R1 enable");
      chk(3'd2, 8'h00, "R1 code");
      chk(3'd5, 8'h00, "R1 istat");
      chk(3'd6, 8'h00, "R1 ien");
      chk_irq(1'b0, "R1 irq");
      chk(3'd3, 8'h11, "R11 tx");
      chk(3'd4, 8'h22, "R11 rx");
      chk(3'd7, 8'h00, "R12 unmapped");
      // R2 bus events
      drive(0, 0, 0, 7'h55, 7'h00);
      chk(3'd0, 8'hAA, "R2 events");
      // R3 R6 protocol errors, last-error mode
      drive(0, 0, 0, 7'h00, 7'h08);
      chk(3'd0, 8'hAB, "R3 bus error");
      chk(3'd2, 8'h08, "R6 first code");
      drive(0, 0, 0, 7'h00, 7'h01);
      chk(3'd2, 8'h01, "R6 replaced");
      // R4 write-zero clear
      drive(1, 3'd0, 8'hF0, 7'h00, 7'h00);
      chk(3'd0, 8'hA0, "R4 clear");
      // R8 mode bit written, bit0 kept
      drive(1, 3'd2, 8'h81, 7'h00, 7'h00);
      chk(3'd2, 8'h81, "R8 mode write");
      // R7 accumulate
      drive(0, 0, 0, 7'h00, 7'h04);
      chk(3'd2, 8'h85, "R7 accum 1");
      drive(0, 0, 0, 7'h00, 7'h20);
      chk(3'd2, 8'hA5, "R7 accum 2");
      chk(3'd0, 8'hA1, "R3 bus error again");
      drive(1, 3'd2, 8'hA0, 7'h00, 7'h00);
      chk(3'd2, 8'hA0, "R8 code clear");
      // R5 priority
      drive(1, 3'd0, 8'h00, 7'h02, 7'h00);
      chk(3'd0, 8'h04, "R5 factor set wins");
      drive(1, 3'd2, 8'h80, 7'h00, 7'h02);
      chk(3'd2, 8'h82, "R5 code set wins");
      chk(3'd0, 8'h05, "R5 R3 factor");
      // R9 enable and summary
      drive(1, 3'd1, 8'h01, 7'h00, 7'h00);
      chk(3'd1, 8'h01, "R9 enable rw");
      chk(3'd5, 8'h20, "R9 summary set");
      chk_irq(1'b0, "R10 irq masked");
      // R10 interrupt enable
      drive(1, 3'd6, 8'hFF, 7'h00, 7'h00);
      chk(3'd6, 8'h20, "R10 ien rw");
      chk_irq(1'b1, "R10 irq on");
      drive(1, 3'd0, 8'hFE, 7'h00, 7'h00);
      chk(3'd0, 8'h04, "R4 clear bit0");
      chk(3'd5, 8'h00, "R9 summary clear");
      chk_irq(1'b0, "R10 irq off");
      drive(1, 3'd1, 8'h04, 7'h00, 7'h00);
      chk(3'd5, 8'h20, "R9 other enable");
      chk_irq(1'b1, "R10 irq again");
      // R12 read-only writes
      drive(1, 3'd5, 8'h00, 7'h00, 7'h00);
      chk(3'd5, 8'h20, "R12 istat ro");
      drive(1, 3'd3, 8'h00, 7'h00, 7'h00);
      drive(1, 3'd7, 8'hFF, 7'h00, 7'h00);
      chk(3'd3, 8'h11, "R12 tx ro");
      chk(3'd7, 8'h00, "R12 unmapped");
      chk(3'd0, 8'h04, "R12 factor untouched");
      // R11 counters track inputs
      @(negedge clk); tx_cnt = 8'h7F; rx_cnt = 8'h80;
      chk(3'd3, 8'h7F, "R11 tx new");
      chk(3'd4, 8'h80, "R11 rx new");
      // R6 back to last-error mode, simultaneous errors
      drive(1, 3'd2, 8'h7F, 7'h00, 7'h00);
      chk(3'd2, 8'h02, "R8 mode cleared");
      drive(0, 0, 0, 7'h00, 7'h41);
      chk(3'd2, 8'h41, "R6 two errors");
      repeat (2) @(negedge clk);
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end
endmodule